// File: doc/BRIEF.md
# RTC Compare/Capture Channel

One compare/capture channel that sits beside a real-time counter. The channel does not count. It watches a main counter and a pre-counter that another block advances, and it uses one step strobe for each of them. In compare mode it raises an event when the selected counter steps onto a programmed 32-bit value. It then changes a single output pin by one of four actions: a one-cycle pulse, toggle, clear or set.

In capture mode it passes a pin through a two-flop synchroniser and looks for the chosen kind of transition. On each detected transition it stores the main counter in a read-only capture register and raises the same event flag. The compare value can be matched against the main counter alone. It can also be matched against a combined value: the pre-counter sits in the low bits and the low main-counter bits sit above it. This gives sub-tick resolution.

Top module: `ccChannel`

## Requirements
- R1: The mode field uses the codes 0 = off, 1 = capture, 2 = compare and 3 = off. In either off code no event is raised, no capture is taken and the output pin keeps its level. In capture mode no compare match is evaluated.
- R2: In compare mode with base bit 0, a cycle with `mainTick` high and `mainCount == cmpValue` raises `eventFlag` for exactly the next cycle.
- R3: In compare mode with base bit 1, the channel forms a combined value: `preCount` in bits 14:0 and `mainCount[16:0]` in bits 31:15. A cycle with `preTick` high and this combined value equal to `cmpValue` is a match. In this base the main-counter strobe alone never matches.
- R4: A match is evaluated only in a cycle in which the selected counter steps. Equal values with no step raise no event and leave the pin alone.
- R5: With action code 0 (pulse), a match drives `cmpOut` high for exactly one clock cycle. The pin then returns low.
- R6: With action code 1 (toggle), each match inverts `cmpOut`.
- R7: With action code 2 (clear), a match drives `cmpOut` low. With code 3 (set), a match drives it high. The new pin level appears in the same cycle as the event flag.
- R8: In capture mode, the edge codes are 0 = rising, 1 = falling and 2 = both. A selected transition on `capIn` stores `mainCount` into `capValue` and raises `eventFlag`. Both happen three clock edges after the pin changes: two edges for synchronisation and one for registering. Transitions that are not selected leave `capValue` unchanged.
- R9: Edge code 3 disables capture: no transition stores a value or raises an event.
- R10: Reset (`rstN` low, asynchronous) forces `cmpOut` low, `eventFlag` low and `capValue` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgMode | input | 2 | 0 off, 1 capture, 2 compare, 3 off |
| cfgAction | input | 2 | Match action: 0 pulse, 1 toggle, 2 clear, 3 set |
| cfgBase | input | 1 | 0 main counter, 1 combined counter |
| cfgEdge | input | 2 | 0 rising, 1 falling, 2 both, 3 none |
| cmpValue | input | 32 | Compare value |
| mainCount | input | 32 | Main counter value, new value in its step cycle |
| preCount | input | 15 | Pre-counter value, new value in its step cycle |
| mainTick | input | 1 | Main counter stepped this cycle |
| preTick | input | 1 | Pre-counter stepped this cycle |
| capIn | input | 1 | Asynchronous capture pin |
| cmpOut | output | 1 | Compare output pin |
| capValue | output | 32 | Last captured main counter value |
| eventFlag | output | 1 | One-cycle pulse per match or capture |

## Verification
Two conditions are hard to reach. The first is the combined-counter base: it must be shown that bits of the main counter above bit 16 are ignored, and that a main-counter step onto an equal value does not fire. The bench drives vectors in which only the upper main bits differ and in which only the wrong strobe is raised. The second is the capture latency through the synchroniser. The bench holds the pin level still between cases and samples the flag both two and three edges after each pin change, so a missing or extra flop shows up as a flag in the wrong cycle.

// File: rtl/ccChanPkg.sv
`timescale 1ns/1ps
package ccChanPkg;
  typedef enum logic [1:0] {
    MODE_OFF     = 2'd0,
    MODE_CAPTURE = 2'd1,
    MODE_COMPARE = 2'd2,
    MODE_RSVD    = 2'd3
  } ccMode_e;

  typedef enum logic [1:0] {
    ACT_PULSE  = 2'd0,
    ACT_TOGGLE = 2'd1,
    ACT_CLEAR  = 2'd2,
    ACT_SET    = 2'd3
  } ccAction_e;

  typedef enum logic [1:0] {
    EDGE_RISE = 2'd0,
    EDGE_FALL = 2'd1,
    EDGE_BOTH = 2'd2,
    EDGE_NONE = 2'd3
  } ccEdge_e;

  typedef struct packed {
    logic pinPulse;
    logic pinToggle;
    logic pinClear;
    logic pinSet;
    logic capture;
    logic evt;
  } ccStrobe_t;
endpackage

// File: rtl/ccChanCtrl.sv
`timescale 1ns/1ps
module ccChanCtrl
  import ccChanPkg::*;
#(
  parameter int CNT_W = 32,
  parameter int PRE_W = 15
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       cfgMode,
  input  logic [1:0]       cfgAction,
  input  logic             cfgBase,
  input  logic [1:0]       cfgEdge,
  input  logic [CNT_W-1:0] cmpValue,
  input  logic [CNT_W-1:0] mainCount,
  input  logic [PRE_W-1:0] preCount,
  input  logic             mainTick,
  input  logic             preTick,
  input  logic             capIn,
  output ccStrobe_t        strb
);
  localparam int LOW_W  = CNT_W - PRE_W;
  localparam int PIPE_W = 3;

  logic [PIPE_W-1:0] capPipe;
  logic [CNT_W-1:0]  combined;
  logic              syncLvl, prevLvl, riseSeen, fallSeen, edgeHit;
  logic              isCompare, isCapture, matchMain, matchComb, match;

  // two synchroniser flops plus one history flop for edge detection
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) capPipe <= '0;
    else       capPipe <= {capPipe[PIPE_W-2:0], capIn};
  end

  assign syncLvl  = capPipe[1];
  assign prevLvl  = capPipe[2];
  assign riseSeen = syncLvl & ~prevLvl;
  assign fallSeen = ~syncLvl & prevLvl;

  always_comb begin
    unique case (ccEdge_e'(cfgEdge))
      EDGE_RISE: edgeHit = riseSeen;
      EDGE_FALL: edgeHit = fallSeen;
      EDGE_BOTH: edgeHit = riseSeen | fallSeen;
      default:   edgeHit = 1'b0;
    endcase
  end

  assign combined  = {mainCount[LOW_W-1:0], preCount};
  assign isCompare = (cfgMode == MODE_COMPARE);
  assign isCapture = (cfgMode == MODE_CAPTURE);
  assign matchMain = !cfgBase && mainTick && (mainCount == cmpValue);
  assign matchComb = cfgBase && preTick && (combined == cmpValue);
  assign match     = isCompare && (matchMain || matchComb);

  always_comb begin
    strb           = '0;
    strb.pinPulse  = match && (cfgAction == ACT_PULSE);
    strb.pinToggle = match && (cfgAction == ACT_TOGGLE);
    strb.pinClear  = match && (cfgAction == ACT_CLEAR);
    strb.pinSet    = match && (cfgAction == ACT_SET);
    strb.capture   = isCapture && edgeHit;
    strb.evt       = match || (isCapture && edgeHit);
  end

  assert_off_quiet_R1: assert property (@(posedge clk) disable iff (!rstN)
    (cfgMode == MODE_OFF || cfgMode == MODE_RSVD) |-> !strb.evt);

  assert_step_gate_R4: assert property (@(posedge clk) disable iff (!rstN)
    (cfgMode == MODE_COMPARE && !mainTick && !preTick) |-> !strb.evt);

  assert_one_action_R7: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.pinPulse, strb.pinToggle, strb.pinClear, strb.pinSet}));

  assert_edge_none_R9: assert property (@(posedge clk) disable iff (!rstN)
    (cfgEdge == EDGE_NONE) |-> !strb.capture);
endmodule

// File: rtl/ccChanDatapath.sv
`timescale 1ns/1ps
module ccChanDatapath
  import ccChanPkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  ccStrobe_t        strb,
  input  logic [CNT_W-1:0] mainCount,
  output logic             cmpOut,
  output logic [CNT_W-1:0] capValue,
  output logic             eventFlag
);
  logic             pinQ, pinNext, pulseHeld;
  logic [CNT_W-1:0] capQ;
  logic             flagQ;
  logic             anyPinStrb;

  assign anyPinStrb = strb.pinPulse | strb.pinToggle | strb.pinClear | strb.pinSet;

  always_comb begin
    pinNext = pinQ;
    if (pulseHeld)      pinNext = 1'b0;
    if (strb.pinToggle) pinNext = ~pinNext;
    if (strb.pinClear)  pinNext = 1'b0;
    if (strb.pinSet)    pinNext = 1'b1;
    if (strb.pinPulse)  pinNext = 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pinQ      <= 1'b0;
      pulseHeld <= 1'b0;
      capQ      <= '0;
      flagQ     <= 1'b0;
    end else begin
      pinQ      <= pinNext;
      pulseHeld <= strb.pinPulse;
      flagQ     <= strb.evt;
      if (strb.capture) capQ <= mainCount;
    end
  end

  assign cmpOut    = pinQ;
  assign capValue  = capQ;
  assign eventFlag = flagQ;

  assert_flag_rise_R2: assert property (@(posedge clk) disable iff (!rstN)
    strb.evt |=> eventFlag);

  assert_flag_quiet_R2: assert property (@(posedge clk) disable iff (!rstN)
    !strb.evt |=> !eventFlag);

  assert_pulse_width_R5: assert property (@(posedge clk) disable iff (!rstN)
    (cmpOut && pulseHeld && !strb.pinSet && !strb.pinToggle && !strb.pinPulse)
      |=> !cmpOut);

  assert_pin_hold_R1: assert property (@(posedge clk) disable iff (!rstN)
    (!pulseHeld && !anyPinStrb) |=> $stable(cmpOut));

  assert_cap_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    !strb.capture |=> $stable(capValue));
endmodule

// File: rtl/ccChannel.sv
`timescale 1ns/1ps
module ccChannel
  import ccChanPkg::*;
#(
  parameter int CNT_W = 32,
  parameter int PRE_W = 15
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       cfgMode,
  input  logic [1:0]       cfgAction,
  input  logic             cfgBase,
  input  logic [1:0]       cfgEdge,
  input  logic [CNT_W-1:0] cmpValue,
  input  logic [CNT_W-1:0] mainCount,
  input  logic [PRE_W-1:0] preCount,
  input  logic             mainTick,
  input  logic             preTick,
  input  logic             capIn,
  output logic             cmpOut,
  output logic [CNT_W-1:0] capValue,
  output logic             eventFlag
);
  ccStrobe_t strb;

  ccChanCtrl #(.CNT_W(CNT_W), .PRE_W(PRE_W)) i_ctrl (
    .clk(clk), .rstN(rstN),
    .cfgMode(cfgMode), .cfgAction(cfgAction), .cfgBase(cfgBase), .cfgEdge(cfgEdge),
    .cmpValue(cmpValue), .mainCount(mainCount), .preCount(preCount),
    .mainTick(mainTick), .preTick(preTick), .capIn(capIn),
    .strb(strb)
  );

  ccChanDatapath #(.CNT_W(CNT_W)) i_data (
    .clk(clk), .rstN(rstN), .strb(strb), .mainCount(mainCount),
    .cmpOut(cmpOut), .capValue(capValue), .eventFlag(eventFlag)
  );

  assert_reset_low_R10: assert property (@(posedge clk)
    !rstN |-> (!cmpOut && !eventFlag && capValue == '0));
endmodule

// File: tb/test_ccChannel.sv
`timescale 1ns/1ps
module test_ccChannel;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  cfgMode = 2'd0, cfgAction = 2'd0, cfgEdge = 2'd0;
  logic        cfgBase = 1'b0;
  logic [31:0] cmpValue = '0, mainCount = '0;
  logic [14:0] preCount = '0;
  logic        mainTick = 1'b0, preTick = 1'b0, capIn = 1'b0;
  logic        cmpOut, eventFlag;
  logic [31:0] capValue;

  int checkCount = 0;
  int failCount = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  ccChannel i_ccChannel (
    .clk(clk), .rstN(rstN), .cfgMode(cfgMode), .cfgAction(cfgAction),
    .cfgBase(cfgBase), .cfgEdge(cfgEdge), .cmpValue(cmpValue),
    .mainCount(mainCount), .preCount(preCount), .mainTick(mainTick),
    .preTick(preTick), .capIn(capIn), .cmpOut(cmpOut),
    .capValue(capValue), .eventFlag(eventFlag)
  );

  typedef struct packed {
    logic [1:0]  mode;
    logic [1:0]  act;
    logic        base;
    logic [31:0] cmp;
    logic [31:0] mainV;
    logic [14:0] preV;
    logic        mt;
    logic        pt;
    logic        expFlag;
    logic        expPin;
  } vec_t;

  localparam int NVEC = 15;
  localparam vec_t VECS [NVEC] = '{
    '{2'd2, 2'd3, 1'b0, 32'd100,      32'd100,      15'd0, 1'b1, 1'b0, 1'b1, 1'b1}, // R2 R7 set
    '{2'd2, 2'd3, 1'b0, 32'd100,      32'd100,      15'd0, 1'b0, 1'b0, 1'b0, 1'b1}, // R4 no step
    '{2'd2, 2'd2, 1'b0, 32'd100,      32'd101,      15'd0, 1'b1, 1'b0, 1'b0, 1'b1}, // R2 mismatch
    '{2'd2, 2'd2, 1'b0, 32'd100,      32'd100,      15'd0, 1'b1, 1'b0, 1'b1, 1'b0}, // R7 clear
    '{2'd2, 2'd1, 1'b0, 32'd100,      32'd100,      15'd0, 1'b1, 1'b0, 1'b1, 1'b1}, // R6 toggle
    '{2'd2, 2'd1, 1'b0, 32'd100,      32'd100,      15'd0, 1'b1, 1'b0, 1'b1, 1'b0}, // R6 toggle
    '{2'd0, 2'd1, 1'b0, 32'd100,      32'd100,      15'd0, 1'b1, 1'b0, 1'b0, 1'b0}, // R1 off
    '{2'd3, 2'd3, 1'b0, 32'd100,      32'd100,      15'd0, 1'b1, 1'b0, 1'b0, 1'b0}, // R1 code 3
    '{2'd1, 2'd3, 1'b0, 32'd100,      32'd100,      15'd0, 1'b1, 1'b0, 1'b0, 1'b0}, // R1 capture mode
    '{2'd2, 2'd3, 1'b1, 32'h0001_0005, 32'h0000_0002, 15'd5, 1'b0, 1'b1, 1'b1, 1'b1}, // R3 combined
    '{2'd2, 2'd3, 1'b1, 32'h0001_0005, 32'h0000_0002, 15'd5, 1'b0, 1'b0, 1'b0, 1'b1}, // R4 no pre step
    '{2'd2, 2'd2, 1'b1, 32'h0001_0005, 32'h0002_0002, 15'd5, 1'b0, 1'b1, 1'b1, 1'b0}, // R3 upper bits ignored
    '{2'd2, 2'd0, 1'b0, 32'd7,        32'd7,        15'd0, 1'b1, 1'b0, 1'b1, 1'b1}, // R5 pulse high
    '{2'd2, 2'd0, 1'b0, 32'd7,        32'd7,        15'd0, 1'b0, 1'b0, 1'b0, 1'b0}, // R5 pulse ends
    '{2'd2, 2'd3, 1'b1, 32'h0001_0005, 32'h0001_0005, 15'd0, 1'b1, 1'b0, 1'b0, 1'b0}  // R3 main step ignored
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checkCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // drive pin change, verify flag timing and captured value
  task automatic capCase(input string req, input logic [1:0] mode, input logic [1:0] edgeSel,
                         input logic lvl, input logic [31:0] cnt,
                         input logic hit, input logic [31:0] expCap);
    cfgMode = mode;
    cfgEdge = edgeSel;
    mainCount = cnt;
    capIn = lvl;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check({req, " flag not before third edge"}, {31'd0, eventFlag}, 32'd0);
    @(posedge clk);
    @(negedge clk);
    check({req, " flag"}, {31'd0, eventFlag}, {31'd0, hit});
    check({req, " value"}, capValue, expCap);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      failCount++;
      checkCount++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R10 reset pin", {31'd0, cmpOut}, 32'd0);
    check("R10 reset flag", {31'd0, eventFlag}, 32'd0);
    check("R10 reset capture", capValue, 32'd0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    for (int i = 0; i < NVEC; i++) begin
      cfgMode   = VECS[i].mode;
      cfgAction = VECS[i].act;
      cfgBase   = VECS[i].base;
      cmpValue  = VECS[i].cmp;
      mainCount = VECS[i].mainV;
      preCount  = VECS[i].preV;
      mainTick  = VECS[i].mt;
      preTick   = VECS[i].pt;
      @(negedge clk);
      check($sformatf("vector %0d flag (R1-table)", i), {31'd0, eventFlag}, {31'd0, VECS[i].expFlag});
      check($sformatf("vector %0d pin", i), {31'd0, cmpOut}, {31'd0, VECS[i].expPin});
    end
    mainTick = 1'b0;
    preTick = 1'b0;
    cfgBase = 1'b0;
    @(negedge clk);

    // capture cases, pin starts low
    capCase("R8 rising capture",     2'd1, 2'd0, 1'b1, 32'h1234, 1'b1, 32'h1234);
    capCase("R8 rising ignores fall", 2'd1, 2'd0, 1'b0, 32'h1111, 1'b0, 32'h1234);
    capCase("R8 falling ignores rise", 2'd1, 2'd1, 1'b1, 32'h2222, 1'b0, 32'h1234);
    capCase("R8 falling capture",    2'd1, 2'd1, 1'b0, 32'h3333, 1'b1, 32'h3333);
    capCase("R8 both rise",          2'd1, 2'd2, 1'b1, 32'h4444, 1'b1, 32'h4444);
    capCase("R8 both fall",          2'd1, 2'd2, 1'b0, 32'h5555, 1'b1, 32'h5555);
    capCase("R9 none rise",          2'd1, 2'd3, 1'b1, 32'h6666, 1'b0, 32'h5555);
    capCase("R9 none fall",          2'd1, 2'd3, 1'b0, 32'h6767, 1'b0, 32'h5555);
    capCase("R1 off ignores edge",   2'd0, 2'd0, 1'b1, 32'h7777, 1'b0, 32'h5555);
    capCase("R1 compare mode ignores edge", 2'd2, 2'd2, 1'b0, 32'h7878, 1'b0, 32'h5555);

    // set pin high, then reset mid-operation
    cfgMode = 2'd2; cfgAction = 2'd3; cfgBase = 1'b0;
    cmpValue = 32'd9; mainCount = 32'd9; mainTick = 1'b1;
    @(negedge clk);
    mainTick = 1'b0;
    check("R7 set before reset", {31'd0, cmpOut}, 32'd1);
    rstN = 1'b0;
    #1;
    check("R10 async reset pin", {31'd0, cmpOut}, 32'd0);
    check("R10 async reset capture", capValue, 32'd0);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
    $finish;
  end
endmodule